// File: doc/BRIEF.md
# Two-Lane Parallel Nine-Sample Recursive Filter

The block computes the first-order recursion y(n) = x(n) + a·y(n−9) at two samples per clock. Every valid cycle it takes an even-indexed and an odd-indexed input sample on two parallel lanes and returns the matching two outputs on two parallel lanes. The coefficient `a` is a run-time input that the block reads on every valid cycle.

The nine-sample feedback does not run through a single delay line. It is split into two cross-lane register chains. The lane-0 result feeds the lane-1 multiplier through 4 registers, and the lane-1 result feeds the lane-0 multiplier through 5 registers. With this split, the two lanes have no combinational path between them. The longest path stays one multiply, one rounding add and one saturating add. The serial delay is a parameter, and the chain lengths and the lane crossing are derived from it.

Samples are signed two's complement. The coefficient is signed with FRAC_W fractional bits. History advances only on valid cycles, so the input stream may contain gaps.

Top module: `unfold2_recur_filt`

## Requirements
- R1: On each cycle with `valid_i` high, `x0_i` is sample x(2k) and `x1_i` is sample x(2k+1). The block returns y(2k) on `y0_o` and y(2k+1) on `y1_o`, where y(n) = x(n) + a·y(n−DLY) and DLY defaults to 9. Lane 0 is the earlier sample in time.
- R2: The product a·y(n−DLY) is formed at full precision. 2^(FRAC_W−1) is added to it and the result is shifted right arithmetically by FRAC_W bits, which rounds half toward +infinity. For example, with a = 0x4000, 3 gives 2 and −3 gives −1.
- R3: The sum x(n) + rounded product is saturated to the signed DATA_W range, which is [−32768, 32767] at the defaults. This applies even when the rounded product itself is +32768 (a = −1.0, y = −32768).
- R4: Reset (`rst_ni` low, asynchronous) clears all feedback history, `y0_o`, `y1_o` and `valid_o` to zero. The first DLY outputs after reset therefore equal their inputs, whatever the coefficient.
- R5: The outputs are registered. The results for a valid input cycle appear on the next clock, with `valid_o` high for exactly that one cycle.
- R6: A cycle with `valid_i` low does not advance the feedback history and leaves `y0_o` and `y1_o` unchanged. The recursion counts only valid samples.
- R7: The coefficient is read on every valid cycle. A new value applies to the samples of that cycle and has no effect on outputs already produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input lanes hold a new sample pair |
| coef_i | input | COEF_W | Signed coefficient a, FRAC_W fractional bits |
| x0_i | input | DATA_W | Even-indexed input sample |
| x1_i | input | DATA_W | Odd-indexed input sample |
| valid_o | output | 1 | Output lanes hold a new result pair |
| y0_o | output | DATA_W | Even-indexed output sample |
| y1_o | output | DATA_W | Odd-indexed output sample |

## Verification
The bench builds the block at the defaults: DATA_W 16, COEF_W 16, FRAC_W 15 and DLY 9, which gives the unequal 4- and 5-register cross-lane chains. At these widths the checks can reach the saturation extremes directly, including the single product that overflows, a = −1.0 times −32768. They can also reach the exact half-way rounding cases. The odd delay makes every feedback path cross lanes. Errors in lane swapping or chain length therefore show up within one history span, and a serial golden model detects them. Idle gaps and a reset in the middle of the run show whether the history holds correctly and clears correctly.

// File: rtl/unfold2_pkg.sv
package unfold2_pkg;
  // Registers on the path from the adder in lane src to the multiplier fed from it
  function automatic int chain_len(int src, int dly);
    return (src + dly) / 2;
  endfunction
  // Multiplier lane fed by adder lane src
  function automatic int chain_dst(int src, int dly);
    return (src + dly) % 2;
  endfunction
endpackage

// File: rtl/lane_mac.sv
module lane_mac #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 15
) (
  input  logic signed [DATA_W-1:0] x_i,
  input  logic signed [DATA_W-1:0] fb_i,
  input  logic signed [COEF_W-1:0] coef_i,
  output logic signed [DATA_W-1:0] y_o
);
  localparam int PROD_W = DATA_W + COEF_W;
  localparam int RND_W  = PROD_W - FRAC_W;
  localparam int SUM_W  = RND_W + 1;
  localparam logic signed [SUM_W-1:0] MAX_V = SUM_W'((2 ** (DATA_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] MIN_V = -SUM_W'(2 ** (DATA_W - 1));
  localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) <<< (FRAC_W - 1);

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] prod_h;
  logic signed [RND_W-1:0]  rnd;
  logic signed [SUM_W-1:0]  sum;

  always_comb begin
    prod   = PROD_W'(fb_i) * PROD_W'(coef_i);
    prod_h = prod + HALF;
    rnd    = RND_W'(prod_h >>> FRAC_W);
    sum    = SUM_W'(x_i) + SUM_W'(rnd);
    if (sum > MAX_V)      y_o = MAX_V[DATA_W-1:0];
    else if (sum < MIN_V) y_o = MIN_V[DATA_W-1:0];
    else                  y_o = sum[DATA_W-1:0];
  end

  // R1
  always_comb if (fb_i == '0) fb_zero_pass_chk: assert (y_o == x_i);
  // R3
  always_comb if (!x_i[DATA_W-1] && !fb_i[DATA_W-1] && !coef_i[COEF_W-1])
    sat_sign_chk: assert (!y_o[DATA_W-1]);
endmodule

// File: rtl/fb_chain.sv
module fb_chain #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic signed [DATA_W-1:0] d_i,
  output logic signed [DATA_W-1:0] q_o
);
  logic signed [DATA_W-1:0] stg [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg[0] <= '0;
    else if (en_i) stg[0] <= d_i;
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else if (en_i) stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[DEPTH-1];

  // R6
  property hold_p;
    @(posedge clk_i) disable iff (!rst_ni) !en_i |=> $stable(q_o);
  endproperty
  chain_hold_chk: assert property (hold_p);
endmodule

// File: rtl/unfold2_recur_filt.sv
module unfold2_recur_filt #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 15,
  parameter int DLY    = 9
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [COEF_W-1:0] coef_i,
  input  logic signed [DATA_W-1:0] x0_i,
  input  logic signed [DATA_W-1:0] x1_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] y0_o,
  output logic signed [DATA_W-1:0] y1_o
);
  import unfold2_pkg::*;
  localparam int LANES = 2;

  logic signed [DATA_W-1:0] x_w   [LANES];
  logic signed [DATA_W-1:0] sum_w [LANES];
  logic signed [DATA_W-1:0] tap_w [LANES];
  logic signed [DATA_W-1:0] fb_w  [LANES];

  assign x_w[0] = x0_i;
  assign x_w[1] = x1_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int LEN = chain_len(g, DLY);
    localparam int DST = chain_dst(g, DLY);

    lane_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_mac (
      .x_i   (x_w[g]),
      .fb_i  (fb_w[g]),
      .coef_i(coef_i),
      .y_o   (sum_w[g])
    );

    fb_chain #(.DATA_W(DATA_W), .DEPTH(LEN)) u_chain (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (valid_i),
      .d_i   (sum_w[g]),
      .q_o   (tap_w[g])
    );

    assign fb_w[DST] = tap_w[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      y0_o    <= '0;
      y1_o    <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        y0_o <= sum_w[0];
        y1_o <= sum_w[1];
      end
    end
  end

  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  // R5
  property vld_align_p;
    @(posedge clk_i) disable iff (!rst_ni) armed_q |-> (valid_o == $past(valid_i));
  endproperty
  vld_align_chk: assert property (vld_align_p);

  // R6
  property out_hold_p;
    @(posedge clk_i) disable iff (!rst_ni) !valid_i |=> ($stable(y0_o) && $stable(y1_o));
  endproperty
  out_hold_chk: assert property (out_hold_p);

  // R5
  property out_cap_p;
    @(posedge clk_i) disable iff (!rst_ni) valid_i |=> (y0_o == $past(sum_w[0]));
  endproperty
  out_cap_chk: assert property (out_cap_p);
endmodule

// File: tb/unfold2_recur_filt_bench.sv
`timescale 1ns/1ps
module unfold2_recur_filt_bench;
  localparam int DLY = 9;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic signed [15:0] coef_i = '0;
  logic signed [15:0] x0_i = '0;
  logic signed [15:0] x1_i = '0;
  logic valid_o;
  logic signed [15:0] y0_o, y1_o;

  always #2.5 clk = ~clk;

  unfold2_recur_filt u_unfold2_recur_filt (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .coef_i(coef_i),
    .x0_i(x0_i), .x1_i(x1_i), .valid_o(valid_o), .y0_o(y0_o), .y1_o(y1_o)
  );

  int checks = 0;
  int errors = 0;
  int yh[$];
  int exp0_q[$];
  int exp1_q[$];
  string tag_q[$];
  logic signed [15:0] last0 = '0, last1 = '0;
  bit done = 0;

  function automatic int model_step(int x, int a);
    longint p;
    longint s;
    int yd;
    yd = (yh.size() >= DLY) ? yh[yh.size() - DLY] : 0;
    p = longint'(a) * longint'(yd);
    p = (p + 16384) >>> 15;
    s = longint'(x) + p;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    yh.push_back(int'(s));
    return int'(s);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(int x0, int x1, int a, string tag);
    @(negedge clk);
    valid_i = 1'b1;
    x0_i = 16'(x0);
    x1_i = 16'(x1);
    coef_i = 16'(a);
    exp0_q.push_back(model_step(x0, a));
    exp1_q.push_back(model_step(x1, a));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
      x0_i = 16'($urandom);
      x1_i = 16'($urandom);
      coef_i = 16'($urandom);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (valid_o) begin
        if (exp0_q.size() == 0) begin
          check("R5 unexpected valid_o", 1, 0);
        end else begin
          string t;
          t = tag_q.pop_front();
          check({t, " lane0"}, int'(y0_o), exp0_q.pop_front());
          check({t, " lane1"}, int'(y1_o), exp1_q.pop_front());
        end
        last0 = y0_o;
        last1 = y1_o;
      end else begin
        // R6 outputs hold across idle cycles
        if (y0_o != last0 || y1_o != last1) check("R6 hold", int'(y0_o), int'(last0));
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R4 reset state
    check("R4 valid_o reset", int'(valid_o), 0);
    check("R4 y0_o reset", int'(y0_o), 0);
    check("R4 y1_o reset", int'(y1_o), 0);
    rst_ni = 1'b1;

    // R4 first nine outputs pass through despite a nonzero coefficient
    for (int i = 0; i < 5; i++) send(100 * i + 7, -50 * i - 3, 16'sh7000, "R4");
    // R1 recursion with fixed coefficient
    for (int i = 0; i < 20; i++) send(1000 + i, -2000 + 3 * i, 16'sh2000, "R1");
    // R2 rounding half cases: a = 0.5 on history of 3 and -3
    idle(2);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    yh.delete();
    last0 = '0; last1 = '0;
    for (int i = 0; i < 5; i++) send(3, -3, 16'sh4000, "R2");
    for (int i = 0; i < 5; i++) send(0, 0, 16'sh4000, "R2");
    // R3 saturation, including a = -1.0 on -32768
    for (int i = 0; i < 10; i++) send(-32768, 32767, 16'sh8000, "R3");
    for (int i = 0; i < 10; i++) send(32767, 32000, 16'sh7fff, "R3");
    // R6 gaps between valid cycles
    for (int i = 0; i < 20; i++) begin
      send(int'($urandom_range(0, 65535)) - 32768, int'($urandom_range(0, 65535)) - 32768,
           16'sh3000, "R6");
      idle(int'($urandom_range(0, 3)));
    end
    // R7 coefficient changes every cycle
    for (int i = 0; i < 300; i++)
      send(int'($urandom_range(0, 65535)) - 32768, int'($urandom_range(0, 65535)) - 32768,
           int'($urandom_range(0, 65535)) - 32768, "R7");
    idle(3);
    // R4 mid-run reset clears history and outputs
    rst_ni = 1'b0;
    @(negedge clk);
    check("R4 mid reset valid_o", int'(valid_o), 0);
    check("R4 mid reset y0_o", int'(y0_o), 0);
    check("R4 mid reset y1_o", int'(y1_o), 0);
    rst_ni = 1'b1;
    yh.delete();
    last0 = '0; last1 = '0;
    for (int i = 0; i < 15; i++) send(-1234 + i, 4321 - i, 16'sh9000, "R4");
    idle(3);
    check("R5 queue drained", exp0_q.size(), 0);
    finish_run();
  end
endmodule